// File: doc/BRIEF.md
# Frequency-Estimation Control Code Calculator

This block works out, in closed form, the control word an oscillator needs to run at N times a reference frequency. Two calibration oscillators run free: one is held at the fastest control setting and the other at the slowest. Between two rising edges of the reference, the block counts the rising edges of each one. These counts are the period ratios `r_max` (fast oscillator) and `r_min` (slow oscillator). The block then evaluates F = T·r_min·(r_max − N) / (N·(r_max − r_min)), where T = 2^CODE_W is the number of control steps. It rounds F to the nearest integer, clamps it into the code range, and presents it with a one-cycle strobe.

All three inputs are sampled in the system clock domain. Each passes through a synchroniser and a rising-edge detector. A shared capture strobe freezes both counts for the same reference period. The arithmetic is a shift-subtract divider that takes one quotient bit per cycle, so a fresh result is ready well before the next reference edge. A measurement that cannot yield a meaningful code leaves the previous code in place and raises an error level instead.

Top module: `fce_code_calc`

## Requirements
- R1: `r_max` and `r_min` show the number of rising edges of `osc_fast_in` and `osc_slow_in` counted over one complete period of `ref_in`.
- R2: `r_max` and `r_min` change only in the cycle of the shared capture, once per reference period. Both values always describe the same period.
- R3: For a valid measurement, `code` equals T·r_min·(r_max − N)/(N·(r_max − r_min)), where T = 2^CODE_W (1024 by default). The result is rounded to the nearest integer, with a fraction of one half rounding up. N is the value on `mult_n` at capture time; any N from 1 to 2^MULT_W − 1 is accepted, including 128.
- R4: A result larger than T − 1 is clamped to T − 1 (1023 by default).
- R5: Each valid measurement produces exactly one `code_valid` pulse, one cycle long. The pulse comes before the next rising edge of the reference.
- R6: `code` changes only in a cycle where `code_valid` is high, and holds its value otherwise.
- R7: A measurement with `r_max <= r_min`, `r_max < N` or N = 0 produces no `code_valid` pulse, keeps `code` unchanged and sets `est_err` high.
- R8: `est_err` is low in every cycle where `code_valid` is high, so the next good result clears an error.
- R9: After reset, `code`, `code_valid`, `est_err`, `r_max` and `r_min` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_in | input | 1 | Reference clock, sampled |
| osc_fast_in | input | 1 | Oscillator running at the fastest control setting |
| osc_slow_in | input | 1 | Oscillator running at the slowest control setting |
| mult_n | input | MULT_W | Multiplication factor N |
| code | output | CODE_W | Computed oscillator control code |
| code_valid | output | 1 | One-cycle strobe marking a new code |
| est_err | output | 1 | Last measurement could not produce a code |
| r_max | output | CNT_W | Fast-oscillator edges per reference period |
| r_min | output | CNT_W | Slow-oscillator edges per reference period |

## Verification
Oscillator speeds and N are chosen so the quotient falls on each distinct path:
- a fraction below one half, which must truncate;
- a fraction above one half, which must round up;
- an exact integer, with N at 128;
- zero, where r_max equals N;
- an overflow that must clamp to 1023.

Two cases exercise the error path, r_max below N and equal counts. In both, the bench checks that the code held is the last one strobed. A following good case shows the error level clearing. Each pattern is held for two reference periods, so repeated recomputation and the one-pulse-per-period rule are both observed.

// File: rtl/fce_pkg.sv
package fce_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_PREP = 2'd1,
      ST_DIV  = 2'd2
   } fce_state_e;

   function automatic int fce_num_width(input int code_w, input int cnt_w);
      return code_w + 2 * cnt_w + 2;
   endfunction

   function automatic int fce_den_width(input int mult_w, input int cnt_w);
      return mult_w + cnt_w + 1;
   endfunction

endpackage

// File: rtl/fce_sync_edge.sv
module fce_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic rise
);

   logic lvl;
   logic lvl_d;

   generate
      if (STAGES == 0) begin : g_direct
         assign lvl = din;
      end else begin : g_chain
         logic [STAGES-1:0] chain;
         for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
               always_ff @(posedge clk or negedge rst_n) begin
                  if (!rst_n) chain[i] <= 1'b0;
                  else        chain[i] <= din;
               end
            end else begin : g_next
               always_ff @(posedge clk or negedge rst_n) begin
                  if (!rst_n) chain[i] <= 1'b0;
                  else        chain[i] <= chain[i-1];
               end
            end
         end
         assign lvl = chain[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_d <= 1'b0;
         rise  <= 1'b0;
      end else begin
         lvl_d <= lvl;
         rise  <= lvl & ~lvl_d;
      end
   end

endmodule

// File: rtl/fce_period_counter.sv
module fce_period_counter #(
   parameter int CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             window_end,
   output logic [CNT_W-1:0] count_q,
   output logic             cap_stb
);

   logic [CNT_W-1:0] acc;
   logic [CNT_W-1:0] acc_inc;
   logic             at_top;

   assign at_top  = &acc;
   assign acc_inc = at_top ? acc : acc + CNT_W'(tick);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc     <= '0;
         count_q <= '0;
         cap_stb <= 1'b0;
      end else begin
         cap_stb <= window_end;
         if (window_end) begin
            count_q <= acc_inc;
            acc     <= '0;
         end else begin
            acc     <= acc_inc;
         end
      end
   end

endmodule

// File: rtl/fce_seq_divider.sv
module fce_seq_divider #(
   parameter int NUM_W = 36,
   parameter int DEN_W = 21
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [NUM_W-1:0] dividend,
   input  logic [DEN_W-1:0] divisor,
   output logic             busy,
   output logic             done,
   output logic [NUM_W-1:0] quotient
);

   localparam int STEP_W = (NUM_W > 1) ? $clog2(NUM_W) : 1;

   logic [DEN_W:0]    rem;
   logic [DEN_W:0]    rem_sh;
   logic [DEN_W:0]    rem_nx;
   logic [NUM_W-1:0]  acc;
   logic [DEN_W-1:0]  den_q;
   logic [STEP_W-1:0] step;
   logic              take;

   always_comb begin
      rem_sh = {rem[DEN_W-1:0], acc[NUM_W-1]};
      take   = (rem_sh >= {1'b0, den_q});
      rem_nx = take ? (rem_sh - {1'b0, den_q}) : rem_sh;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem   <= '0;
         acc   <= '0;
         den_q <= '0;
         step  <= '0;
         busy  <= 1'b0;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         if (start && !busy) begin
            rem   <= '0;
            acc   <= dividend;
            den_q <= divisor;
            step  <= '0;
            busy  <= 1'b1;
         end else if (busy) begin
            rem <= rem_nx;
            acc <= {acc[NUM_W-2:0], take};
            if (step == STEP_W'(NUM_W - 1)) begin
               busy <= 1'b0;
               done <= 1'b1;
            end else begin
               step <= step + 1'b1;
            end
         end
      end
   end

   assign quotient = acc;

endmodule

// File: rtl/fce_code_calc.sv
module fce_code_calc
   import fce_pkg::*;
#(
   parameter int CODE_W        = 10,
   parameter int CNT_W         = 12,
   parameter int MULT_W        = 8,
   parameter int SYNC_STAGES   = 2,
   parameter bit ROUND_NEAREST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ref_in,
   input  logic              osc_fast_in,
   input  logic              osc_slow_in,
   input  logic [MULT_W-1:0] mult_n,
   output logic [CODE_W-1:0] code,
   output logic              code_valid,
   output logic              est_err,
   output logic [CNT_W-1:0]  r_max,
   output logic [CNT_W-1:0]  r_min
);

   localparam int NUM_W   = fce_num_width(CODE_W, CNT_W);
   localparam int DEN_W   = fce_den_width(MULT_W, CNT_W);
   localparam int PROD_W  = 2 * CNT_W;
   localparam int SCALE_W = MULT_W + CNT_W;
   localparam int RAW_W   = PROD_W + CODE_W;

   generate
      if (CNT_W < MULT_W) begin : g_chk_cnt
         $error("CNT_W must be at least MULT_W");
      end
      if (CODE_W < 2) begin : g_chk_code
         $error("CODE_W must be at least 2");
      end
      if (SYNC_STAGES < 0) begin : g_chk_sync
         $error("SYNC_STAGES must not be negative");
      end
   endgenerate

   logic ref_rise, fast_rise, slow_rise;
   logic cap_fast_stb, cap_slow_stb, cap_stb;

   fce_sync_edge #(.STAGES(SYNC_STAGES)) u_sync_ref (
      .clk(clk), .rst_n(rst_n), .din(ref_in), .rise(ref_rise));
   fce_sync_edge #(.STAGES(SYNC_STAGES)) u_sync_fast (
      .clk(clk), .rst_n(rst_n), .din(osc_fast_in), .rise(fast_rise));
   fce_sync_edge #(.STAGES(SYNC_STAGES)) u_sync_slow (
      .clk(clk), .rst_n(rst_n), .din(osc_slow_in), .rise(slow_rise));

   fce_period_counter #(.CNT_W(CNT_W)) u_cnt_fast (
      .clk(clk), .rst_n(rst_n), .tick(fast_rise), .window_end(ref_rise),
      .count_q(r_max), .cap_stb(cap_fast_stb));
   fce_period_counter #(.CNT_W(CNT_W)) u_cnt_slow (
      .clk(clk), .rst_n(rst_n), .tick(slow_rise), .window_end(ref_rise),
      .count_q(r_min), .cap_stb(cap_slow_stb));

   assign cap_stb = cap_fast_stb & cap_slow_stb;

   fce_state_e        state;
   logic [MULT_W-1:0] n_q;
   logic              meas_bad;
   logic [CNT_W-1:0]  hi_gap;
   logic [CNT_W-1:0]  span;
   logic [RAW_W-1:0]  num_raw;
   logic [SCALE_W-1:0] den_raw;
   logic [NUM_W-1:0]  div_num;
   logic [DEN_W-1:0]  div_den;
   logic              div_start;
   logic              div_busy;
   logic              div_done;
   logic [NUM_W-1:0]  div_quo;
   logic              quo_sat;
   logic [CODE_W-1:0] code_nxt;

   always_comb begin
      meas_bad = (mult_n == '0) || (r_max <= r_min) || (r_max < CNT_W'(mult_n));
      hi_gap   = r_max - CNT_W'(n_q);
      span     = r_max - r_min;
      num_raw  = {PROD_W'(r_min) * PROD_W'(hi_gap), {CODE_W{1'b0}}};
      den_raw  = SCALE_W'(n_q) * SCALE_W'(span);
   end

   generate
      if (ROUND_NEAREST) begin : g_round
         assign div_num = (NUM_W'(num_raw) << 1) + NUM_W'(den_raw);
         assign div_den = {den_raw, 1'b0};
      end else begin : g_trunc
         assign div_num = NUM_W'(num_raw);
         assign div_den = DEN_W'(den_raw);
      end
   endgenerate

   assign div_start = (state == ST_PREP);

   fce_seq_divider #(.NUM_W(NUM_W), .DEN_W(DEN_W)) u_div (
      .clk(clk), .rst_n(rst_n), .start(div_start), .dividend(div_num),
      .divisor(div_den), .busy(div_busy), .done(div_done), .quotient(div_quo));

   assign quo_sat  = |div_quo[NUM_W-1:CODE_W];
   assign code_nxt = quo_sat ? {CODE_W{1'b1}} : div_quo[CODE_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         n_q        <= '0;
         code       <= '0;
         code_valid <= 1'b0;
         est_err    <= 1'b0;
      end else begin
         code_valid <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (cap_stb) begin
                  n_q <= mult_n;
                  if (meas_bad) est_err <= 1'b1;
                  else          state   <= ST_PREP;
               end
            end
            ST_PREP: state <= ST_DIV;
            ST_DIV: begin
               if (div_done) begin
                  code       <= code_nxt;
                  code_valid <= 1'b1;
                  est_err    <= 1'b0;
                  state      <= ST_IDLE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/fce_code_calc_chk.sv
module fce_code_calc_chk #(
   parameter int CODE_W = 10,
   parameter int CNT_W  = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic [CODE_W-1:0] code,
   input logic              code_valid,
   input logic              est_err,
   input logic [CNT_W-1:0]  r_max,
   input logic [CNT_W-1:0]  r_min,
   input logic              cap_stb,
   input logic              div_start,
   input logic              div_busy
);

   assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      code_valid |=> !code_valid);

   assert_code_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !code_valid |-> $stable(code));

   assert_err_low_on_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
      code_valid |-> !est_err);

   assert_err_no_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(est_err) |-> !code_valid);

   assert_fast_count_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(r_max) |-> cap_stb);

   assert_slow_count_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(r_min) |-> cap_stb);

   // R3: a new division is launched only when the divider is free
   assert_div_free_R3: assert property (@(posedge clk) disable iff (!rst_n)
      div_start |-> !div_busy);

endmodule

bind fce_code_calc fce_code_calc_chk #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .code(code), .code_valid(code_valid),
   .est_err(est_err), .r_max(r_max), .r_min(r_min), .cap_stb(cap_stb),
   .div_start(div_start), .div_busy(div_busy));

// File: tb/fce_code_calc_test.sv
module fce_code_calc_test;

   localparam int P_REF = 400;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ref_in = 1'b0;
   logic       osc_fast_in = 1'b0;
   logic       osc_slow_in = 1'b0;
   logic [7:0] mult_n = 8'd0;
   logic [9:0] code;
   logic       code_valid;
   logic       est_err;
   logic [11:0] r_max;
   logic [11:0] r_min;

   int checks = 0;
   int fails  = 0;
   int ref_cnt = 0;
   int since_ref = 0;
   int ref_ph = P_REF - 1;
   int hf = 2, hs = 4;
   int fcnt = 0, scnt = 0;
   int mon_fail_r2 = 0, mon_fail_r5 = 0, mon_fail_r6 = 0;
   int last_code = 0;
   logic [9:0]  prev_code = '0;
   logic        prev_vld = 1'b0;
   logic [11:0] prev_max = '0, prev_min = '0;
   bit run_live = 1'b0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   fce_code_calc uut (
      .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .osc_fast_in(osc_fast_in),
      .osc_slow_in(osc_slow_in), .mult_n(mult_n), .code(code),
      .code_valid(code_valid), .est_err(est_err), .r_max(r_max), .r_min(r_min));

   // behavioural reference and oscillator models
   initial begin
      forever begin
         @(posedge clk);
         ref_ph = (ref_ph == P_REF - 1) ? 0 : ref_ph + 1;
         ref_in <= (ref_ph < P_REF / 2);
         if (ref_ph == 0) begin
            ref_cnt++;
            since_ref = 0;
         end else begin
            since_ref++;
         end
         fcnt++;
         if (fcnt >= hf) begin fcnt = 0; osc_fast_in <= ~osc_fast_in; end
         scnt++;
         if (scnt >= hs) begin scnt = 0; osc_slow_in <= ~osc_slow_in; end
      end
   end

   // every-clock monitor
   initial begin
      forever begin
         @(negedge clk);
         if (run_live) begin
            if (code !== prev_code && !code_valid) mon_fail_r6++;
            if (code_valid && prev_vld) mon_fail_r5++;
            if ((r_max !== prev_max || r_min !== prev_min) && since_ref > 8) mon_fail_r2++;
            if (code_valid) last_code = int'(code);
         end
         prev_code = code;
         prev_vld  = code_valid;
         prev_max  = r_max;
         prev_min  = r_min;
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic wait_rise();
      int start = ref_cnt;
      while (ref_cnt == start) @(negedge clk);
   endtask

   task automatic run_case(input int f_half, input int s_half, input int n, input string req);
      int rmx, rmn, expc, vld_cnt, vcode, held;
      bit bad;
      real fr;
      rmx = P_REF / (2 * f_half);
      rmn = P_REF / (2 * s_half);
      bad = (n == 0) || (rmx <= rmn) || (rmx < n);
      expc = 0;
      if (!bad) begin
         fr = 1024.0 * rmn * (rmx - n) / (real'(n) * (rmx - rmn));
         expc = int'($floor(fr + 0.5));
         if (expc > 1023) expc = 1023;
      end
      @(negedge clk);
      hf = f_half;
      hs = s_half;
      mult_n = 8'(n);
      wait_rise();
      wait_rise();
      for (int w = 0; w < 2; w++) begin
         held = last_code;
         vld_cnt = 0;
         vcode = -1;
         for (int i = 0; i < P_REF - 10; i++) begin
            @(negedge clk);
            if (code_valid) begin vld_cnt++; vcode = int'(code); end
         end
         check(r_max == 12'(rmx), "R1", "fast count", r_max, rmx);
         check(r_min == 12'(rmn), "R1", "slow count", r_min, rmn);
         if (bad) begin
            check(vld_cnt == 0, "R7", "pulses on bad measurement", vld_cnt, 0);
            check(est_err == 1'b1, "R7", "error flag", est_err, 1);
            check(int'(code) == held, "R7", "held code", code, held);
         end else begin
            check(vld_cnt == 1, "R5", "pulses in period", vld_cnt, 1);
            check(vcode == expc, req, "strobed code", vcode, expc);
            check(int'(code) == expc, req, "code after strobe", code, expc);
            check(est_err == 1'b0, "R8", "error flag", est_err, 0);
         end
         wait_rise();
      end
   endtask

   initial begin
      repeat (5) @(negedge clk);
      // R9: reset state
      check(code == '0, "R9", "reset code", code, 0);
      check(code_valid == 1'b0, "R9", "reset strobe", code_valid, 0);
      check(est_err == 1'b0, "R9", "reset error", est_err, 0);
      check(r_max == '0 && r_min == '0, "R9", "reset counts", r_max + r_min, 0);
      rst_n = 1'b1;
      run_live = 1'b1;
      run_case(2, 4, 75, "R3");   // 341.33 -> 341 truncates
      run_case(1, 5, 120, "R3");  // 170.67 -> 171 rounds up
      run_case(2, 2, 128, "R3");  // bad: 100 < 128 after equal osc too
      run_case(1, 2, 128, "R3");  // 576 exact, N = 128
      run_case(2, 4, 100, "R3");  // r_max == N -> 0
      run_case(2, 4, 45, "R4");   // 1251.6 -> clamp 1023
      run_case(2, 4, 128, "R7");  // r_max < N
      run_case(4, 4, 45, "R7");   // r_max == r_min
      run_case(1, 4, 64, "R8");   // 725.33 -> 725, error clears
      check(mon_fail_r2 == 0, "R2", "late count changes", mon_fail_r2, 0);
      check(mon_fail_r5 == 0, "R5", "back-to-back strobes", mon_fail_r5, 0);
      check(mon_fail_r6 == 0, "R6", "code changes without strobe", mon_fail_r6, 0);
      if (!finished) begin
         finished = 1'b1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule